// File: doc/BRIEF.md
# Lane Link-Establishment Monitor

This block watches one receive lane of a converter serial link after 8b/10b decoding. Each clock it may take one 32-bit word. The word holds four octets, and each octet has its own control-character flag. A valid strobe qualifies the whole word. The block holds the active-low synchronization request low while the transmitter sends its comma stream. It releases the request on the first octet after that stream that is not a comma.

It then follows the alignment sequence octet by octet, for a parameter number of multiframes. While doing so it checks where the end-of-multiframe and configuration-start characters fall. It stores the fourteen link configuration octets in four readable 32-bit words. It flags lane alignment once the final multiframe of the sequence ends. After that it marks, for each user-data word, which octet opens a multiframe.

The multiframe length in octets is a runtime input. It must lie between 17 and 255. Protocol violations set a sticky error flag.

Top module: `ilas_rx_monitor`

## Requirements
- R1: After reset, sync_n, lane_aligned, somf, err and all four config words are zero.
- R2: sync_n stays low until an octet that is not /K/ (control flag set, value 0xBC) arrives after at least one /K/. It is then high from the cycle after that word. A non-/K/ octet that arrives before any /K/ does not release it.
- R3: The octet that releases sync_n is position 0 of the first alignment multiframe. Each multiframe is mf_len octets long, and positions carry across word boundaries.
- R4: In the alignment phase, an /A/ (control, 0x7C) must appear at position mf_len-1 and nowhere else. A missing /A/ or an extra one sets err.
- R5: Position 1 of the second alignment multiframe must be /Q/ (control, 0x9C). Any other octet there sets err.
- R6: Positions 2 to 15 of the second multiframe are configuration octets n = 0 to 13. Octet n is stored in cfg word n/4, bits 8*(n%4)+7 down to 8*(n%4). Bits 31:16 of cfg3 read as zero.
- R7: lane_aligned rises in the cycle after the word that holds the last /A/ of multiframe ILAS_MF-1. It then stays high until reset.
- R8: After alignment, somf bit i is high in the cycle after a word exactly when octet i of that word is position 0 of a multiframe. The first octet after the final /A/ is such a position.
- R9: A word with in_valid low changes no state. somf is zero in the following cycle.
- R10: err is sticky. A cycle with clr_err high clears it from the next cycle on, and reset also clears it.
- R11: Octet 0 of a word is bits 7:0 with control flag bit 0, and it is handled before octets 1 to 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Link clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_data | input | 32 | Four decoded octets, octet 0 in bits 7:0 |
| in_ctrl | input | 4 | Control-character flag per octet |
| in_valid | input | 1 | Word qualifier |
| mf_len | input | MF_W | Multiframe length in octets (17 to 255) |
| clr_err | input | 1 | Clears the sticky error flag |
| sync_n | output | 1 | Active-low synchronization request |
| lane_aligned | output | 1 | Alignment sequence completed |
| somf | output | 4 | Start-of-multiframe octet marks in the data phase |
| err | output | 1 | Sticky protocol-violation flag |
| cfg0 | output | 32 | Configuration octets 0 to 3 |
| cfg1 | output | 32 | Configuration octets 4 to 7 |
| cfg2 | output | 32 | Configuration octets 8 to 11 |
| cfg3 | output | 32 | Configuration octets 12 and 13, upper half zero |

## Verification
Every result is registered. sync_n, lane_aligned, somf, err and the config words therefore all reflect an input word in the first cycle after the clock edge that accepts it. The bench drives each word on a falling edge and lets one rising edge pass. It then compares all outputs at the next falling edge, before it drives the next word. The expected outputs for a word come from the global octet indices of the stream the bench built, so checks for boundaries in the middle of a word land on exactly that word.

// File: rtl/ilas_rx_monitor.sv
module ilas_rx_monitor #(
  parameter int ILAS_MF = 4,
  parameter int MF_W    = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [31:0]     in_data,
  input  logic [3:0]      in_ctrl,
  input  logic            in_valid,
  input  logic [MF_W-1:0] mf_len,
  input  logic            clr_err,
  output logic            sync_n,
  output logic            lane_aligned,
  output logic [3:0]      somf,
  output logic            err,
  output logic [31:0]     cfg0,
  output logic [31:0]     cfg1,
  output logic [31:0]     cfg2,
  output logic [31:0]     cfg3
);
  localparam int MI_W = (ILAS_MF > 1) ? $clog2(ILAS_MF) : 1;
  localparam logic [7:0] CH_K = 8'hBC;
  localparam logic [7:0] CH_A = 8'h7C;
  localparam logic [7:0] CH_Q = 8'h9C;

  typedef enum logic [1:0] {S_CGS, S_ILAS, S_DATA} st_t;

  st_t            st_q, st_n;
  logic [MF_W-1:0] pos_q, pos_n;
  logic [MI_W-1:0] mfi_q, mfi_n;
  logic            seen_q, seen_n, al_n, err_n;
  logic [3:0]      som_n;
  logic [7:0]      cfg_q [14];
  logic [7:0]      cfg_n [14];
  logic [7:0]      oc;
  logic            kc, last, is_a;
  logic [3:0]      ci;

  always_comb begin
    st_n   = st_q;
    pos_n  = pos_q;
    mfi_n  = mfi_q;
    seen_n = seen_q;
    al_n   = lane_aligned;
    cfg_n  = cfg_q;
    som_n  = '0;
    err_n  = err & ~clr_err;
    oc = '0; kc = 1'b0; last = 1'b0; is_a = 1'b0; ci = '0;
    if (in_valid) begin
      for (int i = 0; i < 4; i++) begin
        oc   = in_data[8*i +: 8];
        kc   = in_ctrl[i];
        last = (pos_n == mf_len - 1'b1);
        is_a = kc && (oc == CH_A);
        ci   = 4'(pos_n - MF_W'(2));
        case (st_n)
          S_CGS: begin
            if (kc && oc == CH_K) seen_n = 1'b1;
            else if (seen_n) begin
              st_n  = S_ILAS;
              pos_n = MF_W'(1);
              mfi_n = '0;
            end
          end
          S_ILAS: begin
            if (is_a != last) err_n = 1'b1;
            if (mfi_n == MI_W'(1) && pos_n == MF_W'(1) && !(kc && oc == CH_Q))
              err_n = 1'b1;
            if (mfi_n == MI_W'(1) && pos_n >= MF_W'(2) && pos_n <= MF_W'(15))
              cfg_n[ci] = oc;
            if (last) begin
              pos_n = '0;
              if (mfi_n == MI_W'(ILAS_MF - 1)) begin
                st_n = S_DATA;
                al_n = 1'b1;
              end else mfi_n = mfi_n + 1'b1;
            end else pos_n = pos_n + 1'b1;
          end
          default: begin
            if (pos_n == '0) som_n[i] = 1'b1;
            pos_n = last ? '0 : pos_n + 1'b1;
          end
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q <= S_CGS; pos_q <= '0; mfi_q <= '0; seen_q <= 1'b0;
      lane_aligned <= 1'b0; somf <= '0; err <= 1'b0;
      for (int j = 0; j < 14; j++) cfg_q[j] <= '0;
    end else begin
      st_q <= st_n; pos_q <= pos_n; mfi_q <= mfi_n; seen_q <= seen_n;
      lane_aligned <= al_n; somf <= som_n; err <= err_n;
      cfg_q <= cfg_n;
    end
  end

  assign sync_n = (st_q != S_CGS);
  assign cfg0 = {cfg_q[3],  cfg_q[2],  cfg_q[1], cfg_q[0]};
  assign cfg1 = {cfg_q[7],  cfg_q[6],  cfg_q[5], cfg_q[4]};
  assign cfg2 = {cfg_q[11], cfg_q[10], cfg_q[9], cfg_q[8]};
  assign cfg3 = {16'h0000,  cfg_q[13], cfg_q[12]};

  AST_ALIGN_NEEDS_SYNC: assert property (@(posedge clk) disable iff (!rst_n)
    lane_aligned |-> sync_n); // R7
  AST_ALIGN_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    lane_aligned |=> lane_aligned); // R7
  AST_SOMF_AFTER_ALIGN: assert property (@(posedge clk) disable iff (!rst_n)
    (somf != 4'b0) |-> lane_aligned); // R8
  AST_SOMF_ONE_PER_WORD: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(somf)); // R8
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (err && !clr_err) |=> err); // R10
  AST_ERR_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_err && !in_valid) |=> !err); // R10
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!in_valid && !clr_err) |=> (somf == 4'b0) && $stable(sync_n) &&
      $stable(lane_aligned) && $stable(err) && $stable(cfg0) && $stable(cfg3)); // R9
endmodule

// File: tb/sim_ilas_rx_monitor.sv
module sim_ilas_rx_monitor;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] in_data = '0;
  logic [3:0]  in_ctrl = '0;
  logic        in_valid = 1'b0;
  logic [7:0]  mf_len = 8'd20;
  logic        clr_err = 1'b0;
  logic        sync_n, lane_aligned, err;
  logic [3:0]  somf;
  logic [31:0] cfg0, cfg1, cfg2, cfg3;

  int tests = 0;
  int fails = 0;

  always #10 clk = ~clk;

  ilas_rx_monitor u0 (
    .clk(clk), .rst_n(rst_n), .in_data(in_data), .in_ctrl(in_ctrl),
    .in_valid(in_valid), .mf_len(mf_len), .clr_err(clr_err),
    .sync_n(sync_n), .lane_aligned(lane_aligned), .somf(somf), .err(err),
    .cfg0(cfg0), .cfg1(cfg1), .cfg2(cfg2), .cfg3(cfg3)
  );

  // fields: mf_len[31:24] k_count[23:16] seed[15:8] fault[7:4] gaps[3:0]
  localparam logic [31:0] SCEN [4] = '{
    {8'd20, 8'd4, 8'h10, 4'd0, 4'd0},
    {8'd18, 8'd3, 8'h30, 4'd0, 4'd1},
    {8'd17, 8'd6, 8'h80, 4'd1, 4'd0},
    {8'd24, 8'd1, 8'h05, 4'd2, 4'd1}
  };

  logic [7:0] ob [512];
  logic       ok [512];

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic step(input logic [31:0] d, input logic [3:0] c, input logic v);
    in_data = d; in_ctrl = c; in_valid = v;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic do_reset();
    rst_n = 1'b0; in_valid = 1'b0; clr_err = 1'b0;
    @(posedge clk); @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  function automatic logic [31:0] cfg_exp(input int w, input logic [7:0] seed);
    logic [31:0] r = '0;
    for (int b = 0; b < 4; b++)
      if (4*w + b < 14) r[8*b +: 8] = seed + 8'(4*w + b);
    return r;
  endfunction

  task automatic run_scen(input logic [31:0] sc, input bit chk_reset);
    int mf, nk, fault, gaps, n, dstart;
    logic [7:0] seed;
    logic [3:0] es;
    logic [31:0] d;
    logic [3:0] c;
    mf = int'(sc[31:24]); nk = int'(sc[23:16]); seed = sc[15:8];
    fault = int'(sc[7:4]); gaps = int'(sc[3:0]);
    n = 0;
    for (int k = 0; k < nk; k++) begin ob[n] = 8'hBC; ok[n] = 1'b1; n++; end
    for (int m = 0; m < 4; m++)
      for (int p = 0; p < mf; p++) begin
        ob[n] = 8'h40 + 8'(p); ok[n] = 1'b0;
        if (p == 0) begin ob[n] = 8'h1C; ok[n] = 1'b1; end
        else if (p == mf-1) begin ob[n] = 8'h7C; ok[n] = 1'b1; end
        else if (m == 1 && p == 1) begin
          if (fault == 1) begin ob[n] = 8'h55; ok[n] = 1'b0; end
          else begin ob[n] = 8'h9C; ok[n] = 1'b1; end
        end
        else if (m == 1 && p <= 15) begin ob[n] = seed + 8'(p-2); ok[n] = 1'b0; end
        else if (fault == 2 && m == 0 && p == mf-2) begin ob[n] = 8'h7C; ok[n] = 1'b1; end
        n++;
      end
    dstart = n;
    for (int q = 0; q < 3*mf; q++) begin ob[n] = 8'hD0 ^ 8'(q); ok[n] = 1'b0; n++; end
    while (n % 4 != 0) begin ob[n] = 8'h11; ok[n] = 1'b0; n++; end
    mf_len = 8'(mf);
    do_reset();
    if (chk_reset) begin
      check("R1 sync_n", {31'b0, sync_n}, 32'd0);
      check("R1 lane_aligned", {31'b0, lane_aligned}, 32'd0);
      check("R1 somf", {28'b0, somf}, 32'd0);
      check("R1 err", {31'b0, err}, 32'd0);
      check("R1 cfg0", cfg0, 32'd0);
      check("R1 cfg3", cfg3, 32'd0);
    end
    for (int w = 0; w < n/4; w++) begin
      if (gaps != 0 && w % 3 == 2) begin
        step(32'h7C7C7C7C, 4'hF, 1'b0);
        check("R9 somf after idle word", {28'b0, somf}, 32'd0);
        check("R9 sync_n held", {31'b0, sync_n}, {31'b0, (4*w-1 >= nk)});
        check("R9 aligned held", {31'b0, lane_aligned}, {31'b0, (4*w-1 >= dstart-1)});
      end
      for (int i = 0; i < 4; i++) begin d[8*i +: 8] = ob[4*w+i]; c[i] = ok[4*w+i]; end
      step(d, c, 1'b1);
      es = '0;
      for (int i = 0; i < 4; i++)
        if (4*w+i >= dstart && ((4*w+i-dstart) % mf) == 0) es[i] = 1'b1;
      check("R2 R3 R11 sync_n", {31'b0, sync_n}, {31'b0, (4*w+3 >= nk)});
      check("R7 lane_aligned", {31'b0, lane_aligned}, {31'b0, (4*w+3 >= dstart-1)});
      check("R8 somf", {28'b0, somf}, {28'b0, es});
    end
    check(fault == 1 ? "R5 err" : "R4 err", {31'b0, err}, {31'b0, fault != 0});
    check("R6 cfg0", cfg0, cfg_exp(0, seed));
    check("R6 cfg1", cfg1, cfg_exp(1, seed));
    check("R6 cfg2", cfg2, cfg_exp(2, seed));
    check("R6 cfg3", cfg3, cfg_exp(3, seed));
  endtask

  initial begin
    #4000000;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    for (int s = 0; s < 4; s++) run_scen(SCEN[s], s == 0);

    // R10: sticky error and explicit clear
    run_scen(SCEN[2], 1'b0);
    step(32'h0, 4'h0, 1'b0);
    check("R10 err sticky", {31'b0, err}, 32'd1);
    clr_err = 1'b1;
    step(32'h0, 4'h0, 1'b0);
    clr_err = 1'b0;
    check("R10 err cleared", {31'b0, err}, 32'd0);
    do_reset();
    check("R10 err after reset", {31'b0, err}, 32'd0);

    // R2: data before any comma does not release sync
    mf_len = 8'd20;
    step(32'h44332211, 4'h0, 1'b1);
    check("R2 no release without comma", {31'b0, sync_n}, 32'd0);
    step(32'hBCBCBCBC, 4'hF, 1'b1);
    check("R2 low during commas", {31'b0, sync_n}, 32'd0);
    step(32'h401CBCBC, 4'h7, 1'b1);
    check("R2 R11 release mid-word", {31'b0, sync_n}, 32'd1);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule